// File: doc/BRIEF.md
# Privileged System Register Access Controller

This block owns one 128-bit register that describes the base of the second-stage translation tables for guests. The register holds a table base address, a guest identifier, a skip-level count and a shared-walk flag. Each request is a read or a write of either 64 bits or a 128-bit pair. The block judges it against the requester's privilege level (0 to 3), three nested-virtualisation control bits and a set of feature and enable inputs. Every request gets exactly one of four outcomes: the access is performed, an undefined-instruction response, a trap with a target level and a syndrome code, or a redirect of the access to a fixed memory offset.

Stored fields are masked to the layout mode in force. In the wide layout the base address is split across two bit ranges and the skip level is present. In the narrow layout the base address is one contiguous range. The upper byte of the guest identifier exists only when the 16-bit identifier feature is present and selected. The shared-walk bit exists only when its feature is present. The table walk, TLB caching and the memory transaction behind a redirect belong to other blocks.

Top module: `s2b_csr_ctrl`

## Requirements
- R1: A request from privilege level 0 gives an undefined response and leaves the stored register unchanged.
- R2: At level 1 with level 2 present, the control pattern nest_ctl with bits 2 and 0 both set gives a redirect with offset 0x020. Otherwise, nest_ctl bit 0 set gives a trap to level 2. Any other pattern gives an undefined response. A redirect or a trap never changes the register.
- R3: A trap raised at level 1 carries syndrome 0x18 for a 64-bit access and 0x14 for a 128-bit pair access.
- R4: At levels 2 and 3, permitted accesses are performed. A 64-bit write updates bits 63:0 only. A 64-bit read returns bits 63:0, with read data bits 127:64 zero.
- R5: A 128-bit pair access at level 2, when level 3 exists and its wide enable is 0, is judged in this order. It is undefined when wide_undef_prio is 1. It is undefined when wide_undef_sel is 1. Otherwise it traps to level 3 with syndrome 0x14. With the enable at 1, or with no level 3, the access is performed. A pair access at level 3 is never blocked.
- R6: In the wide layout (layout128 = 1), only these bits are stored and read back: base 87:80 and 47:5, identifier 63:48, skip level 2:1 and shared-walk bit 0. All other bits are zero.
- R7: In the narrow layout (layout128 = 0), only these bits are stored and read back: identifier 63:48, base 47:1 and shared-walk bit 0. Bits 127:64 read as zero.
- R8: Identifier bits 63:56 are kept only when id16_present and id16_sel are both 1. Otherwise they read as zero.
- R9: With level 2 absent, level 3 accesses are performed but read as zero and writes are ignored. Accesses from levels 0 to 2 are undefined.
- R10: With the shared-walk feature absent (shared_feat = 0), bit 0 reads as zero.
- R11: The register resets to zero. Each strobe yields one response exactly one cycle later with exactly one outcome flag set. No response appears without a strobe. Read data is zero except for a performed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 128-bit pair access, 0 = 64-bit access |
| req_plvl | input | 2 | Requester privilege level |
| req_wdata | input | 128 | Write data (bits 63:0 used for 64-bit writes) |
| nest_ctl | input | 3 | Nested-virtualisation control pattern |
| have_lvl2 | input | 1 | Level 2 is implemented |
| have_lvl3 | input | 1 | Level 3 is implemented |
| wide_en | input | 1 | Level-3 enable for 128-bit pair access |
| wide_undef_prio | input | 1 | Blocked pair access is undefined with priority |
| wide_undef_sel | input | 1 | Blocked pair access is undefined instead of trapping |
| layout128 | input | 1 | Wide field layout selected |
| id16_present | input | 1 | 16-bit identifier feature present |
| id16_sel | input | 1 | 16-bit identifier size selected |
| shared_feat | input | 1 | Shared-walk bit feature present |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | Access performed |
| rsp_undef | output | 1 | Undefined-instruction outcome |
| rsp_trap | output | 1 | Trap outcome |
| rsp_trap_lvl | output | 2 | Trap target level |
| rsp_syndrome | output | 6 | Trap syndrome code |
| rsp_redir | output | 1 | Redirect outcome |
| rsp_redir_off | output | 12 | Redirect memory offset |
| rsp_rdata | output | 128 | Read data |

## Verification
Two functions can meet in one cycle: the outcome decision and the field masking. For example, a level-2 pair write can hit the wide-enable priority chain while the layout or identifier-width inputs are also changing. The random phase varies every configuration input on each request, together with privilege, width and pattern. The bench then compares the whole response vector, and the register contents seen through later reads, with a bench model. Directed cases pin down each priority step, the 64-bit write that must spare bits 127:64, and the blocked and redirected writes that must not change the register.

// File: rtl/s2b_pkg.sv
package s2b_pkg;
    localparam int REG_W  = 128;
    localparam int HALF_W = REG_W / 2;
    localparam int LVL_W  = 2;
    localparam int SYN_W  = 6;
    localparam int OFF_W  = 12;
    localparam int NEST_W = 3;

    localparam logic [SYN_W-1:0] SYN_NARROW = 6'h18;
    localparam logic [SYN_W-1:0] SYN_WIDE   = 6'h14;
    localparam logic [OFF_W-1:0] REDIR_OFF  = 12'h020;

    typedef enum logic [1:0] {
        OUT_DONE  = 2'd0,
        OUT_UNDEF = 2'd1,
        OUT_TRAP  = 2'd2,
        OUT_REDIR = 2'd3
    } outcome_e;

    typedef struct packed {
        outcome_e             kind;
        logic [LVL_W-1:0]     tlvl;
        logic [SYN_W-1:0]     syn;
        logic                 blank;   // performed but backed by nothing
    } verdict_t;

    typedef struct packed {
        logic [REG_W-1:0] store;
        logic             rvalid;
        logic             ok;
        logic             undef;
        logic             trap;
        logic             redir;
        logic [LVL_W-1:0] tlvl;
        logic [SYN_W-1:0] syn;
        logic [REG_W-1:0] rdata;
    } ctl_t;
endpackage

// File: rtl/s2b_access_decode.sv
module s2b_access_decode
    import s2b_pkg::*;
(
    input  logic [LVL_W-1:0]  plvl,
    input  logic              wide,
    input  logic [NEST_W-1:0] nest,
    input  logic              have_lvl2,
    input  logic              have_lvl3,
    input  logic              wide_en,
    input  logic              undef_prio,
    input  logic              undef_sel,
    output verdict_t          verdict
);
    always_comb begin
        verdict = '{kind: OUT_UNDEF, tlvl: '0, syn: '0, blank: 1'b0};
        unique case (plvl)
            2'd0: verdict.kind = OUT_UNDEF;
            2'd1: begin
                if (!have_lvl2) begin
                    verdict.kind = OUT_UNDEF;
                end else if (nest[2] && nest[0]) begin
                    verdict.kind = OUT_REDIR;
                end else if (nest[0]) begin
                    verdict.kind = OUT_TRAP;
                    verdict.tlvl = 2'd2;
                    verdict.syn  = wide ? SYN_WIDE : SYN_NARROW;
                end else begin
                    verdict.kind = OUT_UNDEF;
                end
            end
            2'd2: begin
                if (!have_lvl2) begin
                    verdict.kind = OUT_UNDEF;
                end else if (wide && have_lvl3 && !wide_en) begin
                    if (undef_prio || undef_sel) begin
                        verdict.kind = OUT_UNDEF;
                    end else begin
                        verdict.kind = OUT_TRAP;
                        verdict.tlvl = 2'd3;
                        verdict.syn  = SYN_WIDE;
                    end
                end else begin
                    verdict.kind = OUT_DONE;
                end
            end
            default: begin
                verdict.kind  = OUT_DONE;
                verdict.blank = !have_lvl2;
            end
        endcase
    end
endmodule

// File: rtl/s2b_field_mask.sv
module s2b_field_mask
    import s2b_pkg::*;
#(
    parameter int ID_LO    = 48,
    parameter int ID_W     = 16,
    parameter int BASE_TOP = 47,
    parameter int XBASE_LO = 80,
    parameter int XBASE_W  = 8
) (
    input  logic             layout128,
    input  logic             id16_present,
    input  logic             id16_sel,
    input  logic             shared_feat,
    output logic [REG_W-1:0] mask
);
    localparam int ID_HALF     = ID_W / 2;
    localparam int WIDE_BASE_LO = 5;
    localparam int NARR_BASE_LO = 1;

    logic full_id;
    assign full_id = id16_present && id16_sel;

    always_comb begin
        mask = '0;
        for (int b = 0; b < ID_HALF; b++) mask[ID_LO + b] = 1'b1;
        for (int b = ID_HALF; b < ID_W; b++) mask[ID_LO + b] = full_id;
        mask[0] = shared_feat;
        if (layout128) begin
            for (int b = WIDE_BASE_LO; b <= BASE_TOP; b++) mask[b] = 1'b1;
            for (int b = 0; b < XBASE_W; b++) mask[XBASE_LO + b] = 1'b1;
            mask[2:1] = 2'b11;
        end else begin
            for (int b = NARR_BASE_LO; b <= BASE_TOP; b++) mask[b] = 1'b1;
        end
    end
endmodule

// File: rtl/s2b_csr_ctrl.sv
module s2b_csr_ctrl
    import s2b_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [1:0]        req_plvl,
    input  logic [127:0]      req_wdata,
    input  logic [2:0]        nest_ctl,
    input  logic              have_lvl2,
    input  logic              have_lvl3,
    input  logic              wide_en,
    input  logic              wide_undef_prio,
    input  logic              wide_undef_sel,
    input  logic              layout128,
    input  logic              id16_present,
    input  logic              id16_sel,
    input  logic              shared_feat,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic              rsp_undef,
    output logic              rsp_trap,
    output logic [1:0]        rsp_trap_lvl,
    output logic [5:0]        rsp_syndrome,
    output logic              rsp_redir,
    output logic [11:0]       rsp_redir_off,
    output logic [127:0]      rsp_rdata
);
    verdict_t         verdict;
    logic [REG_W-1:0] fmask;
    logic [REG_W-1:0] view;
    logic [REG_W-1:0] store_q;
    ctl_t             ctl_d, ctl_q;

    s2b_access_decode u_decode (
        .plvl       (req_plvl),
        .wide       (req_wide),
        .nest       (nest_ctl),
        .have_lvl2  (have_lvl2),
        .have_lvl3  (have_lvl3),
        .wide_en    (wide_en),
        .undef_prio (wide_undef_prio),
        .undef_sel  (wide_undef_sel),
        .verdict    (verdict)
    );

    s2b_field_mask u_mask (
        .layout128    (layout128),
        .id16_present (id16_present),
        .id16_sel     (id16_sel),
        .shared_feat  (shared_feat),
        .mask         (fmask)
    );

    assign view = ctl_q.store & fmask;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.rvalid = req_valid;
        ctl_d.ok     = 1'b0;
        ctl_d.undef  = 1'b0;
        ctl_d.trap   = 1'b0;
        ctl_d.redir  = 1'b0;
        ctl_d.tlvl   = '0;
        ctl_d.syn    = '0;
        ctl_d.rdata  = '0;
        if (req_valid) begin
            unique case (verdict.kind)
                OUT_DONE: begin
                    ctl_d.ok = 1'b1;
                    if (!verdict.blank) begin
                        if (req_write) begin
                            if (req_wide) begin
                                ctl_d.store = req_wdata & fmask;
                            end else begin
                                ctl_d.store[HALF_W-1:0] =
                                    req_wdata[HALF_W-1:0] & fmask[HALF_W-1:0];
                            end
                        end else if (req_wide) begin
                            ctl_d.rdata = view;
                        end else begin
                            ctl_d.rdata = {{HALF_W{1'b0}}, view[HALF_W-1:0]};
                        end
                    end
                end
                OUT_UNDEF: ctl_d.undef = 1'b1;
                OUT_TRAP: begin
                    ctl_d.trap = 1'b1;
                    ctl_d.tlvl = verdict.tlvl;
                    ctl_d.syn  = verdict.syn;
                end
                default: ctl_d.redir = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign store_q       = ctl_q.store;
    assign rsp_valid     = ctl_q.rvalid;
    assign rsp_ok        = ctl_q.ok;
    assign rsp_undef     = ctl_q.undef;
    assign rsp_trap      = ctl_q.trap;
    assign rsp_trap_lvl  = ctl_q.tlvl;
    assign rsp_syndrome  = ctl_q.syn;
    assign rsp_redir     = ctl_q.redir;
    assign rsp_redir_off = ctl_q.redir ? REDIR_OFF : '0;
    assign rsp_rdata     = ctl_q.rdata;
endmodule

// File: rtl/s2b_csr_ctrl_chk.sv
module s2b_csr_ctrl_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic         req_wide,
    input logic [1:0]   req_plvl,
    input logic [2:0]   nest_ctl,
    input logic         have_lvl2,
    input logic         rsp_valid,
    input logic         rsp_ok,
    input logic         rsp_undef,
    input logic         rsp_trap,
    input logic [1:0]   rsp_trap_lvl,
    input logic [5:0]   rsp_syndrome,
    input logic         rsp_redir,
    input logic [127:0] rsp_rdata,
    input logic [127:0] store_q
);
    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_ok, rsp_undef, rsp_trap, rsp_redir}) == 1);

    assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> $countones({rsp_ok, rsp_undef, rsp_trap, rsp_redir}) == 0);

    assert_resp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_lvl0_blocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_plvl == 2'd0) |=> (rsp_undef && store_q == $past(store_q)));

    assert_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_plvl == 2'd1 && have_lvl2 && nest_ctl[2] && nest_ctl[0])
        |=> (rsp_redir && store_q == $past(store_q)));

    assert_trap_syndrome_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_trap && rsp_trap_lvl == 2'd2) |-> (rsp_syndrome == 6'h18 || rsp_syndrome == 6'h14));

    assert_narrow_spares_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_wide) |=> store_q[127:64] == $past(store_q[127:64]));

    assert_top_wide_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_plvl == 2'd3) |=> rsp_ok);

    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata[127:88] == '0 && rsp_rdata[79:64] == '0));
endmodule

bind s2b_csr_ctrl s2b_csr_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_wide     (req_wide),
    .req_plvl     (req_plvl),
    .nest_ctl     (nest_ctl),
    .have_lvl2    (have_lvl2),
    .rsp_valid    (rsp_valid),
    .rsp_ok       (rsp_ok),
    .rsp_undef    (rsp_undef),
    .rsp_trap     (rsp_trap),
    .rsp_trap_lvl (rsp_trap_lvl),
    .rsp_syndrome (rsp_syndrome),
    .rsp_redir    (rsp_redir),
    .rsp_rdata    (rsp_rdata),
    .store_q      (store_q)
);

// File: tb/tb_s2b_csr_ctrl.sv
module tb_s2b_csr_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [1:0]   req_plvl = 2'd0;
    logic [127:0] req_wdata = '0;
    logic [2:0]   nest_ctl = 3'd0;
    logic         have_lvl2 = 1'b1, have_lvl3 = 1'b1, wide_en = 1'b1;
    logic         wide_undef_prio = 1'b0, wide_undef_sel = 1'b0;
    logic         layout128 = 1'b1, id16_present = 1'b1, id16_sel = 1'b1, shared_feat = 1'b1;
    logic         rsp_valid, rsp_ok, rsp_undef, rsp_trap, rsp_redir;
    logic [1:0]   rsp_trap_lvl;
    logic [5:0]   rsp_syndrome;
    logic [11:0]  rsp_redir_off;
    logic [127:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    logic [127:0] model = '0;

    always #10 clk = ~clk;

    s2b_csr_ctrl dut (.*);

    function automatic logic [127:0] exp_mask();
        logic [127:0] m = '0;
        m[55:48] = 8'hFF;
        if (id16_present && id16_sel) m[63:56] = 8'hFF;
        m[0] = shared_feat;
        if (layout128) begin
            m[87:80] = 8'hFF;
            m[47:5]  = {43{1'b1}};
            m[2:1]   = 2'b11;
        end else begin
            m[47:1]  = {47{1'b1}};
        end
        return m;
    endfunction

    // outcome: 0 performed, 1 undefined, 2 trap, 3 redirect
    function automatic logic [152:0] expect_rsp(input logic wr, input logic wd,
                                               input logic [1:0] pl, input logic [127:0] wdat,
                                               output logic [127:0] next_model);
        int kind = 1;
        logic [1:0] tl = 0;
        logic [5:0] sy = 0;
        logic [127:0] rd = '0;
        logic [127:0] m = exp_mask();
        next_model = model;
        if (pl == 2'd1 && have_lvl2) begin
            if (nest_ctl[2] && nest_ctl[0]) kind = 3;
            else if (nest_ctl[0]) begin kind = 2; tl = 2; sy = wd ? 6'h14 : 6'h18; end
        end else if (pl == 2'd2 && have_lvl2) begin
            if (wd && have_lvl3 && !wide_en) begin
                if (!(wide_undef_prio || wide_undef_sel)) begin kind = 2; tl = 3; sy = 6'h14; end
            end else kind = 0;
        end else if (pl == 2'd3) kind = 0;
        if (kind == 0 && have_lvl2) begin
            if (wr) begin
                if (wd) next_model = wdat & m;
                else next_model[63:0] = wdat[63:0] & m[63:0];
            end else begin
                rd = model & m;
                if (!wd) rd[127:64] = '0;
            end
        end
        return {1'b1, kind == 0, kind == 1, kind == 2, kind == 3, tl, sy,
                (kind == 3) ? 12'h020 : 12'h000, rd};
    endfunction

    function automatic string tag_of(input logic wd, input logic [1:0] pl);
        if (!have_lvl2) return "R9";
        if (pl == 2'd0) return "R1";
        if (pl == 2'd1) return nest_ctl[0] && !nest_ctl[2] ? "R3" : "R2";
        if (pl == 2'd2 && wd && have_lvl3 && !wide_en) return "R5";
        if (!shared_feat) return "R10";
        if (!(id16_present && id16_sel)) return "R8";
        return layout128 ? "R6" : "R7";
    endfunction

    task automatic check(input string tag, input logic [152:0] act, input logic [152:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic wd, input logic [1:0] pl,
                          input logic [127:0] wdat, input string tag);
        logic [152:0] exp;
        logic [127:0] nm;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wide = wd; req_plvl = pl; req_wdata = wdat;
        exp = expect_rsp(wr, wd, pl, wdat, nm);
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, {rsp_valid, rsp_ok, rsp_undef, rsp_trap, rsp_redir, rsp_trap_lvl,
                    rsp_syndrome, rsp_redir_off, rsp_rdata}, exp);
        model = nm;
    endtask

    localparam logic [127:0] ONES = {128{1'b1}};

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state, quiet outputs, register zero
        check("R11", {rsp_valid, rsp_ok, rsp_undef, rsp_trap, rsp_redir, rsp_trap_lvl,
                      rsp_syndrome, rsp_redir_off, rsp_rdata}, '0);
        access(1'b0, 1'b1, 2'd3, '0, "R11");
        // R6 wide layout
        access(1'b1, 1'b1, 2'd3, ONES, "R6");
        access(1'b0, 1'b1, 2'd3, '0, "R6");
        // R4 narrow write spares upper bits, narrow read
        access(1'b1, 1'b0, 2'd2, '0, "R4");
        access(1'b0, 1'b1, 2'd2, '0, "R4");
        access(1'b1, 1'b0, 2'd2, {64'h0, 64'h1234_5678_9ABC_DEF7}, "R4");
        access(1'b0, 1'b0, 2'd3, '0, "R4");
        // R7 narrow layout
        layout128 = 1'b0;
        access(1'b1, 1'b1, 2'd3, ONES, "R7");
        access(1'b0, 1'b1, 2'd3, '0, "R7");
        // R8 identifier width
        id16_sel = 1'b0;
        access(1'b0, 1'b1, 2'd3, '0, "R8");
        id16_sel = 1'b1; id16_present = 1'b0;
        access(1'b1, 1'b1, 2'd2, ONES, "R8");
        id16_present = 1'b1;
        access(1'b0, 1'b1, 2'd2, '0, "R8");
        // R10 shared-walk bit
        shared_feat = 1'b0;
        access(1'b0, 1'b0, 2'd3, '0, "R10");
        shared_feat = 1'b1;
        layout128 = 1'b1;
        // R1 level 0
        access(1'b1, 1'b1, 2'd0, 128'h5A, "R1");
        access(1'b0, 1'b1, 2'd3, '0, "R1");
        // R2 and R3 level 1 patterns
        for (int p = 0; p < 8; p++) begin
            nest_ctl = 3'(p);
            access(1'b1, 1'b0, 2'd1, ONES, (p == 1 || p == 3) ? "R3" : "R2");
            access(1'b0, 1'b1, 2'd1, '0, (p == 1 || p == 3) ? "R3" : "R2");
        end
        access(1'b0, 1'b1, 2'd3, '0, "R2");
        // R5 priority chain
        wide_en = 1'b0; wide_undef_prio = 1'b1; wide_undef_sel = 1'b1;
        access(1'b1, 1'b1, 2'd2, '0, "R5");
        wide_undef_prio = 1'b0;
        access(1'b1, 1'b1, 2'd2, '0, "R5");
        wide_undef_sel = 1'b0;
        access(1'b1, 1'b1, 2'd2, '0, "R5");
        access(1'b0, 1'b0, 2'd2, '0, "R5");
        access(1'b0, 1'b1, 2'd3, '0, "R5");
        have_lvl3 = 1'b0;
        access(1'b0, 1'b1, 2'd2, '0, "R5");
        have_lvl3 = 1'b1; wide_en = 1'b1;
        access(1'b0, 1'b1, 2'd2, '0, "R5");
        // R9 level 2 absent
        have_lvl2 = 1'b0;
        access(1'b1, 1'b1, 2'd3, 128'h0, "R9");
        access(1'b0, 1'b1, 2'd3, '0, "R9");
        access(1'b0, 1'b1, 2'd2, '0, "R9");
        have_lvl2 = 1'b1;
        access(1'b0, 1'b1, 2'd3, '0, "R9");
        // R11 no strobe, no response
        @(negedge clk);
        check("R11", {rsp_valid, rsp_ok, rsp_undef, rsp_trap, rsp_redir}, '0);
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            logic wr, wd;
            logic [1:0] pl;
            r = $urandom();
            nest_ctl = r[2:0]; have_lvl2 = (r[5:3] != 0); have_lvl3 = r[6];
            wide_en = r[7]; wide_undef_prio = r[8]; wide_undef_sel = r[9];
            layout128 = r[10]; id16_present = r[11] | r[12]; id16_sel = r[13] | r[14];
            shared_feat = r[15] | r[16];
            wr = r[17]; wd = r[18]; pl = r[20:19];
            access(wr, wd, pl, {$urandom(), $urandom(), $urandom(), $urandom()}, tag_of(wd, pl));
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R11: watchdog expired, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule